// File: doc/BRIEF.md
# Two-Port Bidirectional Transfer Unit with Holding Latches

This block moves a parameterised word (8 bits by default) between two ports, A and B, in either direction. Each direction has its own level-sensitive holding latch. When a latch is open it follows its source port, and when it is closed it keeps the last value it saw. A global active-low enable and a direction input decide which port, if any, is driven. The driven port carries either live data from the opposite port or the content of the matching latch, as its select input chooses. An open latch always sends live data, whatever the select input says.

Each bidirectional pad is split into an input value, an output value and a drive flag. The surrounding logic resolves the bus. The latches capture data in every mode, including isolation, so the block can store a word from one or both ports while neither port is driven. An asynchronous active-low reset clears both latches.

Top module: `bus_xcvr_latch`

## Requirements
- R1: While `open_ab` is 1 the A-to-B latch follows `pa_i`. While `open_ab` is 0 it holds the value present when it closed, and seen on `pb_o` with `sel_ab`=1 later changes on `pa_i` have no effect.
- R2: While `open_ba` is 1 the B-to-A latch follows `pb_i`. While `open_ba` is 0 it holds, and seen on `pa_o` with `sel_ba`=1 later changes on `pb_i` have no effect.
- R3: Both latches capture data while `en_n`=1, and the stored words can be read out after the outputs are enabled.
- R4: With `en_n`=0 and `dir_b`=1, `pb_drv`=1 and `pa_drv`=0.
- R5: With `en_n`=0 and `dir_b`=0, `pa_drv`=1 and `pb_drv`=0.
- R6: With `en_n`=1, both `pa_drv` and `pb_drv` are 0.
- R7: A select of 0 (`sel_ab` for B, `sel_ba` for A) puts live data from the opposite port on the output: `pb_o`=`pa_i` or `pa_o`=`pb_i`.
- R8: A select of 1 with the matching latch closed puts the stored word on the output.
- R9: While a latch is open, its output carries live data from the opposite port for both select values.
- R10: While `rst_n`=0 both latches read as all zeros, whatever the open inputs are.
- R11: `pa_drv` and `pb_drv` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both latches |
| en_n | input | 1 | Active-low output enable |
| dir_b | input | 1 | 1: drive port B, 0: drive port A |
| open_ab | input | 1 | A-to-B latch open (transparent) when 1 |
| open_ba | input | 1 | B-to-A latch open (transparent) when 1 |
| sel_ab | input | 1 | Port B source: 0 live A, 1 stored A |
| sel_ba | input | 1 | Port A source: 0 live B, 1 stored B |
| pa_i | input | W | Port A pad input value |
| pa_o | output | W | Port A pad output value |
| pa_drv | output | 1 | Port A drive flag |
| pb_i | input | W | Port B pad input value |
| pb_o | output | W | Port B pad output value |
| pb_drv | output | 1 | Port B drive flag |

## Verification
The block has no clock, so every output is due in the same cycle as its stimulus, with zero register stages. A stored word stays unchanged across any number of later cycles until its latch opens again. The bench first applies the latch-enable and reset changes. One nanosecond later it applies the data and the remaining controls, and it samples one nanosecond after that, well before the next clock edge. Because the latch controls settle before the data moves, no check depends on a race between a closing latch and changing data.

// File: rtl/bus_xcvr_latch.sv
module bus_xcvr_latch #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         en_n,
  input  logic         dir_b,
  input  logic         open_ab,
  input  logic         open_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] pa_i,
  output logic [W-1:0] pa_o,
  output logic         pa_drv,
  input  logic [W-1:0] pb_i,
  output logic [W-1:0] pb_o,
  output logic         pb_drv
);

  logic [W-1:0] hold_ab;
  logic [W-1:0] hold_ba;

  always_latch begin
    if (!rst_n)       hold_ab <= '0;
    else if (open_ab) hold_ab <= pa_i;
  end

  always_latch begin
    if (!rst_n)       hold_ba <= '0;
    else if (open_ba) hold_ba <= pb_i;
  end

  // an open latch always yields live data
  assign pb_o = (sel_ab && !open_ab) ? hold_ab : pa_i;
  assign pa_o = (sel_ba && !open_ba) ? hold_ba : pb_i;

  assign pb_drv = !en_n &&  dir_b;
  assign pa_drv = !en_n && !dir_b;

endmodule

// File: rtl/bus_xcvr_latch_chk.sv
module bus_xcvr_latch_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         en_n,
  input logic         dir_b,
  input logic         open_ab,
  input logic         open_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] pa_i,
  input logic [W-1:0] pa_o,
  input logic         pa_drv,
  input logic [W-1:0] pb_i,
  input logic [W-1:0] pb_o,
  input logic         pb_drv
);

  always_comb begin
    // R11
    excl_drive_chk: assert (!(pa_drv && pb_drv));
    // R6
    iso_quiet_chk: assert (!en_n || (!pa_drv && !pb_drv));
    // R4
    drive_b_chk: assert (en_n || !dir_b || pb_drv);
    // R5
    drive_a_chk: assert (en_n || dir_b || pa_drv);
    // R7
    live_b_chk: assert (sel_ab || pb_o == pa_i);
    // R7
    live_a_chk: assert (sel_ba || pa_o == pb_i);
    // R9
    open_b_chk: assert (!open_ab || pb_o == pa_i);
    // R9
    open_a_chk: assert (!open_ba || pa_o == pb_i);
    // R10
    clr_b_chk: assert (rst_n || !sel_ab || open_ab || pb_o == '0);
    // R10
    clr_a_chk: assert (rst_n || !sel_ba || open_ba || pa_o == '0);
  end

endmodule

bind bus_xcvr_latch bus_xcvr_latch_chk #(.W(W)) u_chk (.*);

// File: tb/bus_xcvr_latch_tb.sv
module bus_xcvr_latch_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en_n, dir_b, open_ab, open_ba, sel_ab, sel_ba;
  logic [W-1:0] pa_i, pb_i, pa_o, pb_o;
  logic pa_drv, pb_drv;

  logic [W-1:0] m_ab, m_ba;
  int checks = 0;
  int errors = 0;

  bus_xcvr_latch #(.W(W)) u_dut (
    .rst_n(rst_n), .en_n(en_n), .dir_b(dir_b),
    .open_ab(open_ab), .open_ba(open_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .pa_i(pa_i), .pa_o(pa_o), .pa_drv(pa_drv),
    .pb_i(pb_i), .pb_o(pb_o), .pb_drv(pb_drv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // latch controls first, then data and other controls, then sample
  task automatic step(input logic rst, input logic en, input logic dr,
                      input logic oab, input logic oba, input logic sab,
                      input logic sba, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    rst_n = rst; open_ab = oab; open_ba = oba;
    if (!rst) begin m_ab = '0; m_ba = '0; end
    else begin
      if (oab) m_ab = pa_i;
      if (oba) m_ba = pb_i;
    end
    #1;
    en_n = en; dir_b = dr; sel_ab = sab; sel_ba = sba; pa_i = a; pb_i = b;
    if (rst) begin
      if (oab) m_ab = a;
      if (oba) m_ba = b;
    end
    #1;
  endtask

  function automatic logic [W-1:0] exp_b();
    return (sel_ab && !open_ab) ? m_ab : pa_i;
  endfunction

  function automatic logic [W-1:0] exp_a();
    return (sel_ba && !open_ba) ? m_ba : pb_i;
  endfunction

  task automatic check_all();
    chk("R11", {31'd0, pa_drv & pb_drv}, 32'd0);
    if (en_n) begin
      chk("R6", {30'd0, pa_drv, pb_drv}, 32'd0);
    end else if (dir_b) begin
      chk("R4", {30'd0, pa_drv, pb_drv}, 32'd1);
    end else begin
      chk("R5", {30'd0, pa_drv, pb_drv}, 32'd2);
    end
    if (pb_drv) chk(open_ab ? "R9" : (sel_ab ? "R8" : "R7"), 32'(pb_o), 32'(exp_b()));
    if (pa_drv) chk(open_ba ? "R9" : (sel_ba ? "R8" : "R7"), 32'(pa_o), 32'(exp_a()));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 0; en_n = 1; dir_b = 0; open_ab = 0; open_ba = 0;
    sel_ab = 0; sel_ba = 0; pa_i = '0; pb_i = '0; m_ab = '0; m_ba = '0;
    r = $urandom(32'h5eed_0042);

    // R10 reset state, even with latches open and data present
    step(0, 0, 1, 1, 1, 1, 1, 8'hF0, 8'h0F);
    step(0, 0, 1, 0, 0, 1, 1, 8'hF0, 8'h0F);
    chk("R10", 32'(pb_o), 32'h00);
    step(0, 0, 0, 0, 0, 1, 1, 8'hF0, 8'h0F);
    chk("R10", 32'(pa_o), 32'h00);

    // R1 open then hold, A to B
    step(1, 0, 1, 1, 0, 1, 1, 8'h3C, 8'h00);
    chk("R1", 32'(pb_o), 32'h3C);
    step(1, 0, 1, 0, 0, 1, 1, 8'h3C, 8'h00);
    step(1, 0, 1, 0, 0, 1, 1, 8'hA5, 8'h00);
    chk("R1", 32'(pb_o), 32'h3C);

    // R2 open then hold, B to A
    step(1, 0, 0, 0, 1, 1, 1, 8'h00, 8'h96);
    chk("R2", 32'(pa_o), 32'h96);
    step(1, 0, 0, 0, 0, 1, 1, 8'h00, 8'h96);
    step(1, 0, 0, 0, 0, 1, 1, 8'h00, 8'h5A);
    chk("R2", 32'(pa_o), 32'h96);

    // R3 store in isolation, read out later
    step(1, 1, 0, 1, 1, 0, 0, 8'h11, 8'h22);
    chk("R6", {30'd0, pa_drv, pb_drv}, 32'd0);
    step(1, 1, 1, 0, 0, 0, 0, 8'h11, 8'h22);
    step(1, 0, 1, 0, 0, 1, 1, 8'hEE, 8'hDD);
    chk("R3", 32'(pb_o), 32'h11);
    step(1, 0, 0, 0, 0, 1, 1, 8'hEE, 8'hDD);
    chk("R3", 32'(pa_o), 32'h22);

    // R9 open latch overrides select
    step(1, 0, 1, 1, 0, 1, 0, 8'h77, 8'h00);
    chk("R9", 32'(pb_o), 32'h77);
    // R7 live data with select low
    step(1, 0, 0, 0, 0, 1, 0, 8'h77, 8'h81);
    chk("R7", 32'(pa_o), 32'h81);

    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      step((r[3:0] != 0), r[4], r[5], r[6], r[7], r[8], r[9],
           r[23:16], r[31:24]);
      check_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule